// File: doc/BRIEF.md
# Dual-Button Timed Reset Generator

This block watches two active-low push buttons and derives two active-low outputs from a press in which both are held together. Pressing only one button, or both at different times, does nothing. The trigger is the two buttons being low at the same moment.

The first output, the prompt output, goes low a short fixed delay after the joint hold begins. It stays low while both buttons stay down and rises as soon as either one is let go. The second output, the reset output, waits for a much longer setup hold. It then emits one low pulse of fixed length. One press gives one pulse, however long the buttons are held. A further pulse can only come after both buttons have been released and pressed again.

The prompt delay is set in microseconds and converted to clock cycles from a clock-frequency parameter. The setup hold and the pulse length are set directly in cycles. The button inputs are taken as already synchronised to the clock.

Top module: `dual_key_reset`

## Requirements
- R1: Holding only one of `key_a_n_i` / `key_b_n_i` low, for any length of time, leaves both `imm_n_o` and `rst_n_o` high.
- R2: With both keys held low starting before clock edge 1, `imm_n_o` reads low after edge IMM_CYC = CLK_HZ*IMM_US/1e6 and stays high before that edge.
- R3: With both keys held low starting before edge 1, `rst_n_o` goes low after edge SETUP_CYC and not before.
- R4: The `rst_n_o` low pulse lasts exactly PULSE_CYC clock cycles.
- R5: Whenever neither output's condition holds, both outputs are high (logic 1 = inactive).
- R6: Releasing either key before a delay expires clears that delay. The next joint hold must again last the full delay before the output asserts.
- R7: `imm_n_o` returns high in the same cycle that either key is released, with no clock edge needed.
- R8: Continued holding after a pulse never produces a second pulse. A new pulse needs both keys released and then a fresh full setup hold.
- R9: Once started, the reset pulse runs its full PULSE_CYC length even if the keys are released during it.
- R10: A synchronous active-high `rst_i` clears all counting. After it, both outputs are high and timing restarts from zero even if the keys are still held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous power-on reset, active high |
| key_a_n_i | input | 1 | First button, active low, synchronised |
| key_b_n_i | input | 1 | Second button, active low, synchronised |
| imm_n_o | output | 1 | Prompt output, active low |
| rst_n_o | output | 1 | Timed reset pulse, active low |

## Verification
The bench samples each output one cycle before and in the cycle of every threshold. An off-by-one delay or pulse length would therefore show up as an early or late edge. A release that comes one cycle short of a threshold, followed by a re-press, catches counters that keep their count instead of clearing. Such a design would fire early on the second press. Long holds after a pulse expose a design that re-arms without a release and pulses again. A release in the middle of the pulse exposes one that cuts the pulse short. A reset applied while the keys are held catches a design that carries stale counts across the reset.

// File: rtl/dual_key_reset.sv
module dual_key_reset #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int IMM_US    = 1500,
  parameter int SETUP_CYC = 250_000_000,
  parameter int PULSE_CYC = 14_000_000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic key_a_n_i,
  input  logic key_b_n_i,
  output logic imm_n_o,
  output logic rst_n_o
);

  localparam longint IMM_L   = (longint'(CLK_HZ) * longint'(IMM_US)) / 64'd1000000;
  localparam int     IMM_CYC = (IMM_L < 1) ? 1 : int'(IMM_L);
  localparam int     IW      = $clog2(IMM_CYC + 1);
  localparam int     CMAX    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int     CW      = $clog2(CMAX + 1);
  localparam logic [IW-1:0] IMM_LIM   = IW'(IMM_CYC);
  localparam logic [CW-1:0] SETUP_END = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);

  typedef enum logic [1:0] {S_ARM, S_PULSE, S_HELD} state_t;

  state_t        state;
  logic [IW-1:0] icnt;
  logic [CW-1:0] scnt;
  logic          both;

  assign both = !key_a_n_i && !key_b_n_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || !both) icnt <= '0;
    else if (icnt != IMM_LIM) icnt <= icnt + 1'b1;
  end

  assign imm_n_o = !(both && icnt == IMM_LIM);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state <= S_ARM;
      scnt  <= '0;
    end else begin
      case (state)
        S_ARM: begin
          if (!both) scnt <= '0;
          else if (scnt == SETUP_END) begin
            state <= S_PULSE;
            scnt  <= '0;
          end else scnt <= scnt + 1'b1;
        end
        S_PULSE: begin
          if (scnt == PULSE_END) begin
            state <= both ? S_HELD : S_ARM;
            scnt  <= '0;
          end else scnt <= scnt + 1'b1;
        end
        S_HELD: begin
          scnt <= '0;
          if (!both) state <= S_ARM;
        end
        default: begin
          state <= S_ARM;
          scnt  <= '0;
        end
      endcase
    end
  end

  assign rst_n_o = (state != S_PULSE);

  AST_IMM_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !imm_n_o |-> $past(!key_a_n_i && !key_b_n_i)); // R2
  AST_PULSE_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_n_o) |-> $past(both)); // R3
  AST_PULSE_RUNS_ON: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == S_PULSE && scnt != PULSE_END) |=> !rst_n_o); // R9
  AST_NO_REPULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rst_n_o) |=> rst_n_o); // R8
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    rst_i |=> (rst_n_o && imm_n_o)); // R10

endmodule

// File: tb/sim_dual_key_reset.sv
module sim_dual_key_reset;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ka  = 1'b1;
  logic kb  = 1'b1;
  logic imm_n, rst_n;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  // CLK_HZ 20 kHz * 1500 us -> 30 cycles prompt delay
  dual_key_reset #(.CLK_HZ(20_000), .IMM_US(1500), .SETUP_CYC(80), .PULSE_CYC(50)) u0 (
    .clk_i(clk), .rst_i(rst), .key_a_n_i(ka), .key_b_n_i(kb),
    .imm_n_o(imm_n), .rst_n_o(rst_n));

  // {key_a, key_b, exp_imm, exp_rst, req[3:0], edges[11:0]}
  localparam int NV = 25;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1111, 4'd5, 12'd5},    // R5 idle
    {4'b0111, 4'd1, 12'd40},   // R1 one key
    {4'b1011, 4'd1, 12'd40},   // R1 other key
    {4'b1111, 4'd5, 12'd2},    // R5
    {4'b0011, 4'd2, 12'd29},   // R2 one short
    {4'b0001, 4'd2, 12'd1},    // R2 at delay
    {4'b1011, 4'd7, 12'd1},    // R7 release
    {4'b0011, 4'd6, 12'd29},   // R6 restarted
    {4'b0001, 4'd2, 12'd1},    // R2
    {4'b0001, 4'd3, 12'd49},   // R3 scnt 79
    {4'b0000, 4'd3, 12'd1},    // R3 pulse starts
    {4'b0000, 4'd4, 12'd49},   // R4 still low
    {4'b0001, 4'd4, 12'd1},    // R4 ends after 50
    {4'b0001, 4'd8, 12'd200},  // R8 long hold
    {4'b1111, 4'd8, 12'd1},    // R8 release
    {4'b0000, 4'd8, 12'd80},   // R8 fresh press
    {4'b1110, 4'd9, 12'd10},   // R9 released mid pulse
    {4'b1110, 4'd9, 12'd39},   // R9
    {4'b1111, 4'd9, 12'd1},    // R9 full length
    {4'b0001, 4'd6, 12'd79},   // R6
    {4'b1111, 4'd6, 12'd1},    // R6 early release
    {4'b0001, 4'd6, 12'd79},   // R6 no carry-over
    {4'b0111, 4'd6, 12'd1},    // R6 one key off
    {4'b0001, 4'd6, 12'd79},   // R6
    {4'b1111, 4'd5, 12'd3}     // R5
  };

  task automatic check(input int req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step(input logic a, input logic b, input int n, input int req,
                      input logic e_imm, input logic e_rst);
    ka = a;
    kb = b;
    repeat (n) @(posedge clk);
    @(negedge clk);
    check(req, "imm_n_o", imm_n, e_imm);
    check(req, "rst_n_o", rst_n, e_rst);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(10, "imm_n_o after reset", imm_n, 1'b1); // R10
    check(10, "rst_n_o after reset", rst_n, 1'b1); // R10
    for (int i = 0; i < NV; i++)
      step(VEC[i][19], VEC[i][18], int'(VEC[i][11:0]), int'(VEC[i][15:12]),
           VEC[i][17], VEC[i][16]);
    // R7: release between edges, seen without a clock edge
    step(1'b0, 1'b0, 30, 7, 1'b0, 1'b1);
    ka = 1'b1;
    #1;
    check(7, "imm_n_o on release", imm_n, 1'b1); // R7
    @(negedge clk);
    // R10: reset during a pulse with keys held
    step(1'b1, 1'b1, 1, 10, 1'b1, 1'b1);
    step(1'b0, 1'b0, 85, 10, 1'b0, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(10, "imm_n_o reset held", imm_n, 1'b1); // R10
    check(10, "rst_n_o reset held", rst_n, 1'b1); // R10
    step(1'b0, 1'b0, 29, 10, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1, 10, 1'b0, 1'b1);
    step(1'b0, 1'b0, 49, 10, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1, 10, 1'b0, 1'b0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule